// File: doc/BRIEF.md
# USB Serial Receive Deserializer

This block sits between the bit-recovery front end of a USB 2.0 device transceiver and the parallel controller side. Each time the front end asserts its bit strobe, the block takes the single-ended line state it presents and turns the serial stream into bytes. It hunts for the SYNC preamble, undoes NRZI coding and drops stuffed bits. It then assembles bytes least significant bit first and flags the end of the packet or any framing violation. Both full speed and high speed are covered: a select input changes only how the end of a packet is recognised.

The controller sees a receive-active flag for the length of a packet and a one-clock byte-valid pulse with the byte beside it. It also sees a one-clock error pulse, and a registered copy of the raw line state that the block outputs on every clock. The byte stream has valid but no ready. The line rate cannot be paused, so there is no back-pressure. The consumer must capture `rx_data` on the clock edge that ends the cycle in which `rx_valid` is high. At least `DATA_W` bit strobes separate two valid pulses.

Top module: `usb_rx_deser`

## Requirements
- R1: While `rst` is high, `rx_active`, `rx_valid` and `rx_error` are 0 and `line_state` is 0 (SE0).
- R2: `line_state` equals `line_in` as it was one clock earlier, on every clock. Bit 0 is D+ and bit 1 is D-, so the codes are 0 = SE0, 1 = J, 2 = K and 3 = SE1.
- R3: `line_in` is interpreted only in cycles where `bit_en` is high. A decoded bit is 0 when the line differs from its value at the previous strobe and 1 when it is the same. Line changes between strobes have no effect on `rx_active`, `rx_valid`, `rx_error` or the received bytes.
- R4: While idle, a run of at least `SYNC_ZEROS` decoded 0s on J/K levels followed by a decoded 1 on K raises `rx_active` on the clock after that strobe. A shorter run leaves `rx_active` low.
- R5: Data bits after the SYNC are packed least significant bit first. After each `DATA_W`-th data bit, `rx_valid` is high for exactly one clock with the byte on `rx_data`. There is no ready input: the consumer takes the byte in that cycle.
- R6: The final bit of the SYNC counts toward the stuffing run. After `STUFF_RUN` consecutive decoded 1s, the next bit is a 0 that is discarded and is not placed in a byte.
- R7: If the bit that follows `STUFF_RUN` consecutive 1s is a 1, `rx_error` pulses for one clock, `rx_active` falls on the same clock and no further byte is delivered.
- R8: At full speed (`fs_sel` = 1), `FS_EOP_SE0` or more SE0 bits followed by J end the packet: `rx_active` falls with no error, and an incomplete byte is discarded without a valid pulse.
- R9: At full speed, an SE0 run shorter than `FS_EOP_SE0` before J, an SE0 run followed by K or SE1, or an SE1 bit during a packet each pulse `rx_error` and drop `rx_active`.
- R10: At high speed (`fs_sel` = 0), the first SE0 bit during a packet ends it with `rx_active` falling and no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-time strobe from the recovery front end |
| line_in | input | 2 | Sampled line state, bit 0 = D+, bit 1 = D- |
| fs_sel | input | 1 | 1 = full-speed rules, 0 = high-speed rules |
| line_state | output | 2 | Registered raw line state |
| rx_active | output | 1 | A packet is being received |
| rx_valid | output | 1 | One-clock pulse: `rx_data` holds a new byte |
| rx_data | output | DATA_W | Received byte |
| rx_error | output | 1 | One-clock pulse on a stuffing or framing violation |

## Verification
The bench keeps the defaults `SYNC_ZEROS` = 5, `STUFF_RUN` = 6 and `FS_EOP_SE0` = 2, with a strobe every fourth clock. A SYNC that starts from high-speed SE0 idle yields only six usable transitions. A three-transition preamble falls short, so both sides of the SYNC threshold are reached. With a run of six, an all-ones payload forces a stuffed zero twice within sixteen data bits, and a run of unstuffed ones reaches the violation in five data bits. With the two-bit SE0 rule, a single SE0 before J separates a malformed end from a proper one.

// File: rtl/usb_rx_pkg.sv
package usb_rx_pkg;

  // Line codes: bit 0 = D+, bit 1 = D-
  localparam logic [1:0] LS_SE0 = 2'd0;
  localparam logic [1:0] LS_J   = 2'd1;
  localparam logic [1:0] LS_K   = 2'd2;
  localparam logic [1:0] LS_SE1 = 2'd3;

  typedef enum logic {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_t;

  // Per-strobe view of the line produced by the NRZI stage
  typedef struct packed {
    logic dbit;     // decoded bit (1 = no change)
    logic jk_pair;  // both current and previous levels are J or K
    logic is_j;
    logic is_k;
    logic se0;
    logic se1;
  } bit_info_t;

endpackage

// File: rtl/usb_rx_nrzi.sv
module usb_rx_nrzi
  import usb_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [1:0] line_in,
  output bit_info_t  info
);

  logic [1:0] prev_q;
  logic       cur_jk;
  logic       prev_jk;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= LS_J;
    end else if (bit_en) begin
      prev_q <= line_in;
    end
  end

  always_comb begin
    cur_jk       = (line_in == LS_J) || (line_in == LS_K);
    prev_jk      = (prev_q == LS_J) || (prev_q == LS_K);
    info.dbit    = (line_in == prev_q);
    info.jk_pair = cur_jk && prev_jk;
    info.is_j    = (line_in == LS_J);
    info.is_k    = (line_in == LS_K);
    info.se0     = (line_in == LS_SE0);
    info.se1     = (line_in == LS_SE1);
  end

endmodule

// File: rtl/usb_rx_ctrl.sv
module usb_rx_ctrl
  import usb_rx_pkg::*;
#(
  parameter int SYNC_ZEROS = 5,
  parameter int STUFF_RUN  = 6,
  parameter int FS_EOP_SE0 = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_en,
  input  logic      fs_sel,
  input  bit_info_t info,
  output logic      rx_active,
  output logic      rx_error,
  output logic      start,
  output logic      data_stb,
  output logic      data_bit
);

  localparam int ZW = $clog2(SYNC_ZEROS + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam int EW = $clog2(FS_EOP_SE0 + 1);
  localparam logic [ZW-1:0] ZMAX = ZW'(SYNC_ZEROS);
  localparam logic [OW-1:0] OMAX = OW'(STUFF_RUN);
  localparam logic [EW-1:0] EMAX = EW'(FS_EOP_SE0);

  rx_state_t       state_q, state_d;
  logic [ZW-1:0]   zero_q, zero_d;
  logic [OW-1:0]   ones_q, ones_d;
  logic [EW-1:0]   se0_q, se0_d;
  logic            err_q, err_d;

  always_comb begin
    state_d  = state_q;
    zero_d   = zero_q;
    ones_d   = ones_q;
    se0_d    = se0_q;
    err_d    = 1'b0;
    start    = 1'b0;
    data_stb = 1'b0;
    data_bit = info.dbit;
    if (bit_en) begin
      case (state_q)
        RX_IDLE: begin
          if (!info.jk_pair) begin
            zero_d = '0;
          end else if (!info.dbit) begin
            if (zero_q < ZMAX) zero_d = zero_q + 1'b1;
          end else if (info.is_k && (zero_q == ZMAX)) begin
            state_d = RX_BUSY;
            ones_d  = OW'(1);
            se0_d   = '0;
            zero_d  = '0;
            start   = 1'b1;
          end else begin
            zero_d = '0;
          end
        end
        RX_BUSY: begin
          if (info.se0) begin
            if (!fs_sel) begin
              state_d = RX_IDLE;
            end else if (se0_q < EMAX) begin
              se0_d = se0_q + 1'b1;
            end
          end else if (se0_q != '0) begin
            state_d = RX_IDLE;
            se0_d   = '0;
            err_d   = !(info.is_j && (se0_q == EMAX));
          end else if (info.se1) begin
            state_d = RX_IDLE;
            err_d   = 1'b1;
          end else if (ones_q == OMAX) begin
            if (info.dbit) begin
              state_d = RX_IDLE;
              err_d   = 1'b1;
            end else begin
              ones_d = '0;
            end
          end else begin
            data_stb = 1'b1;
            ones_d   = info.dbit ? ones_q + 1'b1 : '0;
          end
        end
        default: state_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RX_IDLE;
      zero_q  <= '0;
      ones_q  <= '0;
      se0_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      zero_q  <= zero_d;
      ones_q  <= ones_d;
      se0_q   <= se0_d;
      err_q   <= err_d;
    end
  end

  assign rx_active = (state_q == RX_BUSY);
  assign rx_error  = err_q;

endmodule

// File: rtl/usb_rx_shift.sv
module usb_rx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              data_stb,
  input  logic              data_bit,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);

  localparam int CW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);

  logic [DATA_W-1:0] shreg_q;
  logic [DATA_W-1:0] shreg_nx;
  logic [CW-1:0]     cnt_q;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  // LSB-first: new bit enters at the top and moves down
  assign shreg_nx = {data_bit, shreg_q[DATA_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (start) begin
        cnt_q <= '0;
      end else if (data_stb) begin
        shreg_q <= shreg_nx;
        if (cnt_q == LAST) begin
          cnt_q   <= '0;
          data_q  <= shreg_nx;
          valid_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign rx_valid = valid_q;
  assign rx_data  = data_q;

endmodule

// File: rtl/usb_rx_deser.sv
module usb_rx_deser
  import usb_rx_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int SYNC_ZEROS = 5,
  parameter int STUFF_RUN  = 6,
  parameter int FS_EOP_SE0 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic [1:0]        line_in,
  input  logic              fs_sel,
  output logic [1:0]        line_state,
  output logic              rx_active,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_error
);

  bit_info_t  info;
  logic       start;
  logic       data_stb;
  logic       data_bit;
  logic [1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= LS_SE0;
    else     line_q <= line_in;
  end
  assign line_state = line_q;

  usb_rx_nrzi u_nrzi (
    .clk     (clk),
    .rst     (rst),
    .bit_en  (bit_en),
    .line_in (line_in),
    .info    (info)
  );

  usb_rx_ctrl #(
    .SYNC_ZEROS (SYNC_ZEROS),
    .STUFF_RUN  (STUFF_RUN),
    .FS_EOP_SE0 (FS_EOP_SE0)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .bit_en    (bit_en),
    .fs_sel    (fs_sel),
    .info      (info),
    .rx_active (rx_active),
    .rx_error  (rx_error),
    .start     (start),
    .data_stb  (data_stb),
    .data_bit  (data_bit)
  );

  usb_rx_shift #(
    .DATA_W (DATA_W)
  ) u_shift (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .data_stb (data_stb),
    .data_bit (data_bit),
    .rx_valid (rx_valid),
    .rx_data  (rx_data)
  );

endmodule

// File: rtl/usb_rx_deser_chk.sv
module usb_rx_deser_chk (
  input logic       clk,
  input logic       rst,
  input logic       bit_en,
  input logic [1:0] line_in,
  input logic [1:0] line_state,
  input logic       rx_active,
  input logic       rx_valid,
  input logic       rx_error
);

  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!rx_valid && !rx_error && !rx_active));

  assert_line_mirror_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    line_state == $past(line_in));

  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (rst || !armed)
    !$past(bit_en) |-> $stable(rx_active));

  assert_rise_on_strobe_R4: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(rx_active) |-> $past(bit_en));

  assert_valid_in_packet_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_active);

  assert_valid_single_R5: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  assert_error_drops_R7: assert property (@(posedge clk) disable iff (rst)
    rx_error |-> !rx_active);

  assert_error_from_packet_R9: assert property (@(posedge clk) disable iff (rst || !armed)
    rx_error |-> $past(rx_active));

  assert_fall_on_strobe_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(rx_active) |-> $past(bit_en));

endmodule

bind usb_rx_deser usb_rx_deser_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .bit_en     (bit_en),
  .line_in    (line_in),
  .line_state (line_state),
  .rx_active  (rx_active),
  .rx_valid   (rx_valid),
  .rx_error   (rx_error)
);

// File: tb/tb_usb_rx_deser.sv
`timescale 1ns/1ps
module tb_usb_rx_deser;

  localparam logic [1:0] SE0 = 2'd0, J = 2'd1, K = 2'd2, SE1 = 2'd3;

  // stimulus/expected table: {fs_sel, 16-bit payload = two bytes, low first}
  localparam int NVEC = 8;
  localparam logic [16:0] VEC [NVEC] = '{
    {1'b1, 16'hA5C3}, {1'b1, 16'hFFFF}, {1'b1, 16'h0000}, {1'b0, 16'h7E3F},
    {1'b0, 16'hFFFF}, {1'b1, 16'h80FE}, {1'b0, 16'h0102}, {1'b1, 16'hF00F}
  };

  logic       clk = 0;
  logic       rst = 1;
  logic       bit_en = 0;
  logic [1:0] line_in = J;
  logic       fs_sel = 1;
  logic [1:0] line_state;
  logic       rx_active, rx_valid, rx_error;
  logic [7:0] rx_data;

  int n_tests = 0, n_fail = 0;
  logic [1:0] lvl;
  int ones;
  logic [7:0] got [4];
  int got_n;
  bit err_seen;
  int vbad;
  bit done = 0;

  always #4 clk = ~clk;

  usb_rx_deser dut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .line_in(line_in), .fs_sel(fs_sel),
    .line_state(line_state), .rx_active(rx_active), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_error(rx_error)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bit time: strobe for one clock, sample, then two quiet clocks
  task automatic strobe(input logic [1:0] ln);
    @(negedge clk);
    line_in = ln;
    bit_en  = 1;
    @(negedge clk);
    bit_en = 0;
    if (rx_valid) begin
      if (got_n < 4) got[got_n] = rx_data;
      got_n++;
    end
    if (rx_error) err_seen = 1;
    @(negedge clk);
    if (rx_valid) vbad++;
    @(negedge clk);
  endtask

  task automatic toggle();
    lvl = (lvl == J) ? K : J;
  endtask

  task automatic send_sync();
    lvl = J;
    for (int i = 0; i < 7; i++) begin toggle(); strobe(lvl); end
    strobe(lvl);
    ones = 1;
    got_n = 0;
    err_seen = 0;
  endtask

  task automatic send_bit(input logic b);
    if (!b) toggle();
    strobe(lvl);
    ones = b ? ones + 1 : 0;
    if (ones == 6) begin toggle(); strobe(lvl); ones = 0; end
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic eop_fs();
    strobe(SE0); strobe(SE0); strobe(J); lvl = J;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(!rx_active && !rx_valid && !rx_error && line_state == SE0, "R1 reset",
          {rx_active, rx_valid, rx_error, line_state}, 0);
    @(negedge clk); rst = 0;

    // R2: line_state mirrors line_in one clock later
    for (int c = 0; c < 4; c++) begin
      line_in = 2'(c);
      @(negedge clk);
      check(line_state == 2'(c), "R2 line code", line_state, c);
    end
    line_in = J;
    repeat (3) strobe(J);

    // table walk: R4 R5 R6 R8 R10
    vbad = 0;
    for (int v = 0; v < NVEC; v++) begin
      fs_sel = VEC[v][16];
      repeat (3) strobe(fs_sel ? J : SE0);
      send_sync();
      check(rx_active == 1, "R4 sync raises active", rx_active, 1);
      send_byte(VEC[v][7:0]);
      send_byte(VEC[v][15:8]);
      if (fs_sel) eop_fs(); else strobe(SE0);
      check(got_n == 2, "R5 byte count", got_n, 2);
      check(got[0] == VEC[v][7:0] && got[1] == VEC[v][15:8], "R6 payload",
            {got[0], got[1]}, {VEC[v][7:0], VEC[v][15:8]});
      check(!rx_active && !err_seen, fs_sel ? "R8 fs eop" : "R10 hs eop",
            {rx_active, err_seen}, 0);
    end
    check(vbad == 0, "R5 valid one clock", vbad, 0);
    fs_sel = 1;
    repeat (3) strobe(J);

    // R7: stuffing violation
    send_sync();
    repeat (5) strobe(lvl);
    check(rx_active == 1, "R7 active before violation", rx_active, 1);
    strobe(lvl);
    check(err_seen && !rx_active, "R7 stuff error", {err_seen, rx_active}, 2);
    check(got_n == 0, "R7 no byte", got_n, 0);
    @(negedge clk);
    check(!rx_error, "R7 error one clock", rx_error, 0);
    repeat (3) strobe(J);

    // R9: single SE0 before J
    send_sync();
    send_byte(8'h55);
    strobe(SE0);
    check(rx_active && !err_seen, "R9 one SE0 keeps packet", {rx_active, err_seen}, 2);
    strobe(J);
    check(err_seen && !rx_active && got_n == 1 && got[0] == 8'h55, "R9 short SE0 error",
          {err_seen, rx_active, got[0]}, {1'b1, 1'b0, 8'h55});
    repeat (3) strobe(J); lvl = J;

    // R9: SE1 in packet
    send_sync();
    strobe(SE1);
    check(err_seen && !rx_active, "R9 SE1 error", {err_seen, rx_active}, 2);
    repeat (3) strobe(J);

    // R9: SE0 run followed by K
    send_sync();
    strobe(SE0); strobe(SE0); strobe(K);
    check(err_seen && !rx_active, "R9 SE0 then K error", {err_seen, rx_active}, 2);
    repeat (3) strobe(J);

    // R8: partial byte dropped at EOP
    send_sync();
    send_bit(1); send_bit(0); send_bit(1);
    strobe(SE0);
    check(rx_active == 1, "R8 first SE0 keeps packet", rx_active, 1);
    strobe(SE0); strobe(J); lvl = J;
    check(!rx_active && !err_seen && got_n == 0, "R8 partial dropped",
          {rx_active, err_seen, 8'(got_n)}, 0);

    // R4: preamble too short
    repeat (3) strobe(J);
    got_n = 0; err_seen = 0;
    strobe(K); strobe(J); strobe(K); strobe(K);
    check(!rx_active, "R4 short sync ignored", rx_active, 0);
    repeat (4) strobe(J);
    check(!rx_active && got_n == 0, "R4 stays idle", {rx_active, 8'(got_n)}, 0);

    // R3: line glitch between strobes ignored
    send_sync();
    @(negedge clk); line_in = SE0;
    @(negedge clk);
    check(line_state == SE0, "R2 glitch visible", line_state, SE0);
    line_in = lvl;
    @(negedge clk);
    check(rx_active && !rx_error, "R3 glitch ignored", {rx_active, rx_error}, 2);
    send_byte(8'h96);
    eop_fs();
    check(got_n == 1 && got[0] == 8'h96 && !err_seen, "R3 byte after glitch",
          got[0], 8'h96);

    // R10: HS single SE0 ends packet, no error
    fs_sel = 0;
    repeat (2) strobe(SE0);
    send_sync();
    send_byte(8'h3C);
    strobe(SE0);
    check(!rx_active && !err_seen && got[0] == 8'h3C, "R10 hs end",
          {rx_active, err_seen, got[0]}, 8'h3C);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule